// File: doc/BRIEF.md
# Framed FPGA Configuration Loader

This block drives a downstream FPGA through its byte-wide configuration port. A start pulse opens a load. The block first pulses the active-low program pin for a set number of clocks. It then waits for the target's active-low init pin to go high, which means the target is ready. After that it writes a fixed eight-byte header. The payload arrives from an upstream source over a valid/ready handshake. Each group of 21 payload bytes is wrapped in its own 28-write frame.

The init and done pins from the target are brought into the clock domain through synchronizers. Before each frame the loader checks that the target is still ready (init high) and not yet configured (done low). When the frames are used up, or the target reports done early, four startup bytes follow. The block then reports success, or one of three error codes. Consecutive port writes are spaced by a programmable gap so that the port's strobe timing is met.

Top module: `cfg_frame_loader`

## Requirements
- R1: After reset `prog_n` is 1 and `cfg_wr`, `busy`, `load_done`, `load_error` and `src_ready` are 0, with `err_code` 0.
- R2: A `start` pulse while idle drives `prog_n` low for exactly PROG_LOW_CYC clocks, after which `prog_n` stays high. A `start` pulse while `busy` is 1 has no effect.
- R3: No write reaches the configuration port while the synchronized `init_n` is low. The first eight writes are, in order, 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B.
- R4: Each frame is 28 writes: 0x4F, then 21 payload bytes in arrival order, then 0x4B, 0xFF, 0x4B, 0xFF, 0xFF, 0xFF.
- R5: Exactly `num_frames` frames are written, which consumes 21×`num_frames` payload bytes. With `num_frames` = 0 the header is followed directly by the startup bytes.
- R6: After the last frame, four 0xFF startup writes follow. If `done_in` is then high, `load_done` is set, `err_code` stays 0 and `busy` falls.
- R7: If `init_n` stays low for INIT_TIMEOUT clocks after `prog_n` is released, the load ends with no port write: `load_error` is 1 and `err_code` is 1 (init timeout).
- R8: If `init_n` is low at a frame boundary, the load ends with no further writes and no startup bytes: `load_error` is 1 and `err_code` is 2 (init lost).
- R9: If `done_in` is low after the startup bytes, `load_error` is 1 and `err_code` is 3 (done missing).
- R10: Two port writes are always at least WR_GAP+1 clocks apart.
- R11: If `done_in` is high at a frame boundary, the remaining frames are skipped and the startup bytes follow, ending in success.
- R12: `src_ready` is high only in payload slots of a frame. While `src_valid` is low the frame stalls and no other byte is written in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a load while idle |
| num_frames | input | FRAME_CNT_W | Number of 21-byte payload frames, sampled at start |
| prog_n | output | 1 | Active-low program pin to the target |
| init_n | input | 1 | Target ready pin, active-low while not ready (asynchronous) |
| done_in | input | 1 | Target configuration-complete pin (asynchronous) |
| src_data | input | 8 | Payload byte |
| src_valid | input | 1 | Payload byte is present |
| src_ready | output | 1 | Loader takes the payload byte this clock |
| cfg_data | output | 8 | Byte written to the configuration port |
| cfg_wr | output | 1 | One-clock write strobe for `cfg_data` |
| busy | output | 1 | A load is in progress |
| load_done | output | 1 | Last load completed successfully |
| load_error | output | 1 | Last load failed |
| err_code | output | 2 | 0 none, 1 init timeout, 2 init lost, 3 done missing |

## Verification
The port stream is captured in full and compared byte by byte with a stream built from the frame rules. Four load shapes are used. A two-frame load with a steady source checks the frame layout against the header. A three-frame load with a source that is valid only one clock in three shows that stalls delay the frame without inserting or reordering bytes. A zero-frame load and a load with done high from the start show the two paths that skip frames. The failure runs each stop at a different point: one never raises init, one drops init in the middle of the first frame, and one leaves done low. The differing write counts and error codes tell apart where each load was cut off.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_INITW, ST_HDR, ST_CHK, ST_FRM, ST_START, ST_FIN
  } ld_state_t;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_INIT_TO   = 2'd1,
    ERR_INIT_LOST = 2'd2,
    ERR_NO_DONE   = 2'd3
  } ld_err_t;

  localparam int HDR_LAST   = 7;   // header writes 0..7
  localparam int PAY_FIRST  = 1;   // payload slots inside a frame
  localparam int PAY_LAST   = 21;
  localparam int FRM_LAST   = 27;  // 28 writes per frame
  localparam int START_LAST = 3;   // four startup writes

  function automatic logic [7:0] hdr_byte(input logic [2:0] i);
    case (i)
      3'd3:    return 8'h4F;
      3'd4:    return 8'h80;
      3'd5:    return 8'hAF;
      3'd6:    return 8'h9B;
      3'd7:    return 8'h4B;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] frm_byte(input logic [4:0] i, input logic [7:0] pay);
    if (i == 5'd0) return 8'h4F;
    if (i >= 5'(PAY_FIRST) && i <= 5'(PAY_LAST)) return pay;
    if (i == 5'd22 || i == 5'd24) return 8'h4B;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/cfg_write_pacer.sv
module cfg_write_pacer #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic ready
);
  localparam int CW = (GAP < 1) ? 1 : $clog2(GAP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (fire)        cnt <= CW'(GAP);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader
  import cfg_loader_pkg::*;
#(
  parameter int PROG_LOW_CYC = 16,
  parameter int INIT_TIMEOUT = 2000,
  parameter int WR_GAP       = 2,
  parameter int FRAME_CNT_W  = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [FRAME_CNT_W-1:0] num_frames,
  output logic                   prog_n,
  input  logic                   init_n,
  input  logic                   done_in,
  input  logic [7:0]             src_data,
  input  logic                   src_valid,
  output logic                   src_ready,
  output logic [7:0]             cfg_data,
  output logic                   cfg_wr,
  output logic                   busy,
  output logic                   load_done,
  output logic                   load_error,
  output logic [1:0]             err_code
);
  localparam int PW = $clog2(PROG_LOW_CYC + 1);
  localparam int TW = $clog2(INIT_TIMEOUT + 1);
  localparam int CW = (PW > TW) ? PW : TW;

  ld_state_t              state;
  logic [CW-1:0]          cnt;
  logic [4:0]             idx;
  logic [FRAME_CNT_W-1:0] frames_left;
  logic                   init_s, done_s;
  logic                   pace_ok, fire, want_wr, pay_slot;
  logic [7:0]             nxt_byte;

  cfg_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_init_sync (
    .clk(clk), .rst(rst), .din(init_n), .dout(init_s));
  cfg_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(clk), .rst(rst), .din(done_in), .dout(done_s));
  cfg_write_pacer #(.GAP(WR_GAP)) u_pacer (
    .clk(clk), .rst(rst), .fire(fire), .ready(pace_ok));

  // byte selection for the current slot
  always_comb begin
    want_wr  = 1'b0;
    pay_slot = 1'b0;
    nxt_byte = 8'hFF;
    case (state)
      ST_HDR: begin
        want_wr  = 1'b1;
        nxt_byte = hdr_byte(idx[2:0]);
      end
      ST_FRM: begin
        pay_slot = (idx >= 5'(PAY_FIRST)) && (idx <= 5'(PAY_LAST));
        want_wr  = pay_slot ? src_valid : 1'b1;
        nxt_byte = frm_byte(idx, src_data);
      end
      ST_START: want_wr = 1'b1;
      default: ;
    endcase
  end

  assign fire      = want_wr && pace_ok;
  assign src_ready = pay_slot && pace_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      idx         <= '0;
      frames_left <= '0;
      prog_n      <= 1'b1;
      cfg_wr      <= 1'b0;
      cfg_data    <= 8'h00;
      busy        <= 1'b0;
      load_done   <= 1'b0;
      load_error  <= 1'b0;
      err_code    <= ERR_NONE;
    end else begin
      cfg_wr <= fire;
      if (fire) cfg_data <= nxt_byte;
      case (state)
        ST_IDLE: if (start) begin
          busy        <= 1'b1;
          load_done   <= 1'b0;
          load_error  <= 1'b0;
          err_code    <= ERR_NONE;
          prog_n      <= 1'b0;
          cnt         <= CW'(PROG_LOW_CYC - 1);
          frames_left <= num_frames;
          state       <= ST_PROG;
        end
        ST_PROG: begin
          if (cnt == '0) begin
            prog_n <= 1'b1;
            state  <= ST_INITW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_INITW: begin
          if (init_s) begin
            idx   <= '0;
            state <= ST_HDR;
          end else if (cnt == CW'(INIT_TIMEOUT - 1)) begin
            busy       <= 1'b0;
            load_error <= 1'b1;
            err_code   <= ERR_INIT_TO;
            state      <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HDR: if (fire) begin
          if (idx == 5'(HDR_LAST)) state <= ST_CHK;
          else                     idx   <= idx + 1'b1;
        end
        ST_CHK: begin
          idx <= '0;
          if (done_s || frames_left == '0) begin
            state <= ST_START;
          end else if (!init_s) begin
            busy       <= 1'b0;
            load_error <= 1'b1;
            err_code   <= ERR_INIT_LOST;
            state      <= ST_IDLE;
          end else begin
            state <= ST_FRM;
          end
        end
        ST_FRM: if (fire) begin
          if (idx == 5'(FRM_LAST)) begin
            frames_left <= frames_left - 1'b1;
            state       <= ST_CHK;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_START: if (fire) begin
          if (idx == 5'(START_LAST)) state <= ST_FIN;
          else                       idx   <= idx + 1'b1;
        end
        ST_FIN: begin
          busy <= 1'b0;
          if (done_s) begin
            load_done <= 1'b1;
          end else begin
            load_error <= 1'b1;
            err_code   <= ERR_NO_DONE;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checks
  assert_prog_in_load_R2: assert property (@(posedge clk) disable iff (rst)
    !prog_n |-> busy);
  assert_wr_after_prog_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |-> prog_n);
  assert_payload_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (src_valid && src_ready) |=> (cfg_wr && cfg_data == $past(src_data)));
  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(load_done && load_error));
  assert_err_code_R7: assert property (@(posedge clk) disable iff (rst)
    load_error |-> (err_code != ERR_NONE));
  assert_ready_in_load_R12: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> busy);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !cfg_wr);

  generate
    if (WR_GAP > 0) begin : g_gap_chk
      assert_wr_gap_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !cfg_wr);
    end
  endgenerate
endmodule

// File: tb/cfg_frame_loader_bench.sv
module cfg_frame_loader_bench;
  localparam int PLC = 8;
  localparam int ITO = 100;
  localparam int GAP = 2;
  localparam int FW  = 16;

  logic clk = 0, rst = 1, start = 0;
  logic [FW-1:0] num_frames = '0;
  logic prog_n, init_n = 0, done_in = 0;
  logic [7:0] src_data;
  logic src_valid, src_ready;
  logic [7:0] cfg_data;
  logic cfg_wr, busy, load_done, load_error;
  logic [1:0] err_code;

  int errors = 0, checks = 0;
  int cyc = 0, wn = 0, prog_low = 0, sent = 0;
  logic [7:0] wlog [0:511];
  int wcyc [0:511];
  bit src_en = 0, stall = 0;

  always #4 clk = ~clk;

  cfg_frame_loader #(.PROG_LOW_CYC(PLC), .INIT_TIMEOUT(ITO), .WR_GAP(GAP),
                     .FRAME_CNT_W(FW), .SYNC_STAGES(2)) u_cfg_frame_loader (
    .clk(clk), .rst(rst), .start(start), .num_frames(num_frames),
    .prog_n(prog_n), .init_n(init_n), .done_in(done_in),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .cfg_data(cfg_data), .cfg_wr(cfg_wr), .busy(busy),
    .load_done(load_done), .load_error(load_error), .err_code(err_code));

  function automatic logic [7:0] pat(input int k);
    logic [31:0] v;
    v = k * 37 + 11;
    return v[7:0];
  endfunction

  assign src_data  = pat(sent);
  assign src_valid = src_en && (!stall || (cyc % 3 == 0));

  always @(posedge clk) if (src_valid && src_ready) sent <= sent + 1;

  always @(negedge clk) begin
    cyc++;
    if (cfg_wr && wn < 512) begin
      wlog[wn] = cfg_data;
      wcyc[wn] = cyc;
      wn++;
    end
    if (!prog_n) prog_low++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected < 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i, input int n, input int base);
    int f, o;
    if (i < 8) begin
      case (i)
        3: return 8'h4F; 4: return 8'h80; 5: return 8'hAF;
        6: return 8'h9B; 7: return 8'h4B; default: return 8'hFF;
      endcase
    end
    if (i < 8 + 28 * n) begin
      f = (i - 8) / 28;
      o = (i - 8) % 28;
      if (o == 0) return 8'h4F;
      if (o <= 21) return pat(base + f * 21 + o - 1);
      if (o == 22 || o == 24) return 8'h4B;
      return 8'hFF;
    end
    return 8'hFF;
  endfunction

  task automatic check_stream(input string req, input int n, input int base, input int total);
    int bad = -1;
    for (int i = 0; i < total && i < wn; i++)
      if (bad < 0 && wlog[i] !== exp_byte(i, n, base)) bad = i;
    if (bad >= 0) chk(0, req, wlog[bad], exp_byte(bad, n, base));
    else          chk(1, req, 0, 0);
  endtask

  task automatic check_gap;
    int mind = 1000;
    for (int i = 1; i < wn; i++)
      if (wcyc[i] - wcyc[i-1] < mind) mind = wcyc[i] - wcyc[i-1];
    chk(wn < 2 || mind >= GAP + 1, "R10 write spacing", mind, GAP + 1);
  endtask

  // done_at: -1 never, 0 from the start, >0 once that many writes are logged
  // drop_at: -1 never, >0 drop init_n once that many writes are logged
  task automatic run_load(input int n, input bit stl, input bit give_init,
                          input int done_at, input int drop_at, output int base);
    int t;
    @(posedge clk);
    wn = 0; prog_low = 0;
    base = sent;
    @(negedge clk);
    stall = stl; src_en = 1; done_in = (done_at == 0); init_n = 0;
    num_frames = FW'(n); start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    chk(wn == 0, "R3 no write while init low", wn, 0);
    chk(prog_low == PLC, "R2 program pulse length", prog_low, PLC);
    start = 1; @(negedge clk); start = 0;   // ignored while busy
    if (give_init) init_n = 1;
    t = 0;
    while (busy && t < 20000) begin
      @(negedge clk);
      t++;
      if (done_at > 0 && wn >= done_at) done_in = 1;
      if (drop_at > 0 && wn >= drop_at) init_n = 0;
    end
    chk(!busy, "R6 load finishes", busy, 0);
    repeat (4) @(negedge clk);
    chk(prog_low == PLC, "R2 second start ignored", prog_low, PLC);
    src_en = 0;
  endtask

  task automatic t_reset;
    chk(prog_n == 1 && cfg_wr == 0 && src_ready == 0, "R1 reset pins",
        {prog_n, cfg_wr, src_ready}, 3'b100);
    chk(busy == 0 && load_done == 0 && load_error == 0 && err_code == 0,
        "R1 reset status", {busy, load_done, load_error, err_code}, 0);
  endtask

  task automatic t_normal;
    int base;
    run_load(2, 0, 1, 8 + 56, -1, base);
    chk(wn == 8 + 56 + 4, "R5 write count two frames", wn, 68);
    check_stream("R4 frame layout and R3 header", 2, base, 68);
    chk(sent - base == 42, "R5 payload consumed", sent - base, 42);
    chk(load_done == 1 && load_error == 0 && err_code == 0, "R6 success",
        {load_done, load_error, err_code}, 4'b1000);
    check_gap();
  endtask

  task automatic t_stall;
    int base;
    run_load(3, 1, 1, 8 + 84, -1, base);
    chk(wn == 8 + 84 + 4, "R12 write count under stall", wn, 96);
    check_stream("R12 stalled stream", 3, base, 96);
    chk(sent - base == 63, "R12 payload consumed", sent - base, 63);
    chk(load_done == 1, "R6 success after stall", load_done, 1);
    check_gap();
  endtask

  task automatic t_zero;
    int base;
    run_load(0, 0, 1, 8, -1, base);
    chk(wn == 12, "R5 zero frames count", wn, 12);
    check_stream("R5 zero frames stream", 0, base, 12);
    chk(sent == base, "R12 no payload taken", sent - base, 0);
  endtask

  task automatic t_timeout;
    int base;
    run_load(2, 0, 0, -1, -1, base);
    chk(wn == 0, "R7 no writes on timeout", wn, 0);
    chk(load_error == 1 && err_code == 1, "R7 timeout code",
        {load_error, err_code}, 3'b101);
  endtask

  task automatic t_drop;
    int base;
    run_load(3, 0, 1, -1, 20, base);
    chk(wn == 36, "R8 stop at frame boundary", wn, 36);
    check_stream("R8 partial stream", 1, base, 36);
    chk(load_error == 1 && err_code == 2 && load_done == 0, "R8 init lost code",
        {load_done, load_error, err_code}, 4'b0110);
  endtask

  task automatic t_nodone;
    int base;
    run_load(1, 0, 1, -1, -1, base);
    chk(wn == 40, "R9 full stream written", wn, 40);
    chk(load_error == 1 && err_code == 3, "R9 done missing code",
        {load_error, err_code}, 3'b111);
  endtask

  task automatic t_early;
    int base;
    run_load(3, 0, 1, 0, -1, base);
    chk(wn == 12, "R11 frames skipped", wn, 12);
    check_stream("R11 header then startup", 0, base, 12);
    chk(load_done == 1 && err_code == 0, "R11 early success",
        {load_done, err_code}, 3'b100);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_stall();
    t_zero();
    t_timeout();
    t_drop();
    t_nodone();
    t_early();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule